// File: doc/BRIEF.md
# Converter Interrupt Status Register

This block collects single-cycle event pulses from an analog-to-digital converter controller and holds each one as a sticky flag until software acknowledges it. Ten flags are kept: converter ready, end of sampling, regular end of conversion, regular end of sequence, regular overrun, injected end of conversion, injected end of sequence, and one flag per analog watchdog (three by default). The converter datapath, the sequencer and the threshold comparators live elsewhere. They only drive the event inputs.

Software reaches the flags through a small word-addressed register bus. Writing a one to a status bit clears that flag. The two end-of-conversion flags also drop when the matching data register is read, which other logic signals with a read strobe. When a regular result arrives while the previous end-of-conversion flag is still pending, the block raises the overrun flag. An enable register with the same bit layout masks the flags into one combined interrupt line.

Top module: `cvt_irq_status`

## Requirements
- R1: After reset all flags and all enable bits are zero and `irq` is low.
- R2: Each event pulse sets its flag on the following clock edge, and the flag stays set with no further pulse. Status bit positions: ready 0, sampling end 1, regular conversion end 2, regular sequence end 3, overrun 4, injected conversion end 5, injected sequence end 6, watchdog k (k = 0..2) at bit 7+k.
- R3: A bus write to the status word (address 0) clears, on the next edge, every flag whose write-data bit is 1. Write-data bits that are 0 leave their flags unchanged.
- R4: When a set event and a clear (write-one or read-clear) hit the same flag in the same cycle, the flag ends up set.
- R5: A regular data read strobe clears bit 2, and an injected data read strobe clears bit 5. The clear becomes visible one cycle after the strobe. During the strobe cycle the flag still reads as set.
- R6: Overrun (bit 4) is set when a regular conversion-end event arrives while bit 2 is already set, including in a cycle where bit 2 is being cleared. It is not set when bit 2 is clear.
- R7: Address 0 reads the status flags and address 1 reads the enable register, which a write to address 1 loads from write-data bits 0..9. Bits above 9, other addresses, and any cycle without `bus_rd` read as zero.
- R8: `irq` is high exactly when some flag and its matching enable bit are both set. It follows the flags and enables in the same cycle (default variant).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address (0 status, 1 enable) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero when not reading |
| ev_ready | input | 1 | Converter ready event |
| ev_smp_end | input | 1 | Regular sampling-phase end event |
| ev_conv_end | input | 1 | Regular conversion result available |
| ev_seq_end | input | 1 | Regular sequence finished |
| ev_inj_conv_end | input | 1 | Injected conversion result available |
| ev_inj_seq_end | input | 1 | Injected group finished |
| ev_wdog | input | NUM_WDOG | Per-watchdog threshold crossing events |
| rd_reg_data | input | 1 | Regular data register is being read |
| rd_inj_data | input | 1 | Injected data register is being read |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bound checker watches, on every cycle, the per-flag rules: a set event always lands, a write-one without a concurrent set always empties its flag, read strobes empty the conversion flags, overrun rises only after a conversion-end event on a pending flag, and the interrupt stays low while nothing is flagged. The register map, the zero read-back of unused bits and addresses, the masking done by the enable register, and the exact cycle in which a read-clear becomes visible to software can only be shown by the bench scenarios, which compare every read and the interrupt against a behavioural model.

// File: rtl/cvt_irq_pkg.sv
package cvt_irq_pkg;
   // status/enable bit positions (software-visible layout)
   localparam int unsigned BIT_RDY  = 0;
   localparam int unsigned BIT_SMP  = 1;
   localparam int unsigned BIT_EOC  = 2;
   localparam int unsigned BIT_EOS  = 3;
   localparam int unsigned BIT_OVR  = 4;
   localparam int unsigned BIT_IEOC = 5;
   localparam int unsigned BIT_IEOS = 6;
   localparam int unsigned BIT_WD0  = 7;
   localparam int unsigned N_FIXED  = 7;

   // word offsets on the register bus
   localparam int unsigned OFS_STATUS = 0;
   localparam int unsigned OFS_ENABLE = 1;
endpackage

// File: rtl/cvt_irq_flag.sv
module cvt_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // set has priority so a hardware event is never lost to a clear
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end
endmodule

// File: rtl/cvt_irq_regif.sv
module cvt_irq_regif
   import cvt_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned NFLAG  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NFLAG-1:0]  flags_i,
   output logic [NFLAG-1:0]  w1c_o,
   output logic [NFLAG-1:0]  en_o,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

   logic sel_status, sel_enable;
   logic wdata_hi_unused;

   assign sel_status      = (bus_addr == A_STATUS);
   assign sel_enable      = (bus_addr == A_ENABLE);
   assign wdata_hi_unused = ^bus_wdata[DATA_W-1:NFLAG];

   // write-one-to-clear strobes toward the flag cells
   assign w1c_o = (bus_wr && sel_status) ? bus_wdata[NFLAG-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)                   en_o <= '0;
      else if (bus_wr && sel_enable) en_o <= bus_wdata[NFLAG-1:0];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_status)      bus_rdata[NFLAG-1:0] = flags_i;
         else if (sel_enable) bus_rdata[NFLAG-1:0] = en_o;
      end
   end
endmodule

// File: rtl/cvt_irq_combine.sv
module cvt_irq_combine #(
   parameter int unsigned NFLAG   = 10,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] flags_i,
   input  logic [NFLAG-1:0] en_i,
   output logic             irq_o
);
   logic any_pend;
   assign any_pend = |(flags_i & en_i);

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= any_pend;
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign irq_o = any_pend;
   end
endmodule

// File: rtl/cvt_irq_status.sv
module cvt_irq_status
   import cvt_irq_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned NUM_WDOG = 3,
   parameter bit          RDCLR_EN = 1'b1,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                ev_ready,
   input  logic                ev_smp_end,
   input  logic                ev_conv_end,
   input  logic                ev_seq_end,
   input  logic                ev_inj_conv_end,
   input  logic                ev_inj_seq_end,
   input  logic [NUM_WDOG-1:0] ev_wdog,
   input  logic                rd_reg_data,
   input  logic                rd_inj_data,
   output logic                irq
);
   localparam int unsigned NFLAG = N_FIXED + NUM_WDOG;

   if (NUM_WDOG < 1 || NFLAG >= DATA_W || ADDR_W < 1) begin : g_param_err
      $error("cvt_irq_status: NUM_WDOG, DATA_W or ADDR_W out of range");
   end

   logic [NFLAG-1:0] flag_q;
   logic [NFLAG-1:0] set_vec;
   logic [NFLAG-1:0] w1c_vec;
   logic [NFLAG-1:0] rdclr_vec;
   logic [NFLAG-1:0] clr_vec;
   logic [NFLAG-1:0] en_vec;

   // hardware set sources; overrun uses the pre-clear conversion flag
   always_comb begin
      set_vec           = '0;
      set_vec[BIT_RDY]  = ev_ready;
      set_vec[BIT_SMP]  = ev_smp_end;
      set_vec[BIT_EOC]  = ev_conv_end;
      set_vec[BIT_EOS]  = ev_seq_end;
      set_vec[BIT_OVR]  = ev_conv_end & flag_q[BIT_EOC];
      set_vec[BIT_IEOC] = ev_inj_conv_end;
      set_vec[BIT_IEOS] = ev_inj_seq_end;
      set_vec[NFLAG-1:BIT_WD0] = ev_wdog;
   end

   if (RDCLR_EN) begin : g_rdclr
      always_comb begin
         rdclr_vec           = '0;
         rdclr_vec[BIT_EOC]  = rd_reg_data;
         rdclr_vec[BIT_IEOC] = rd_inj_data;
      end
   end else begin : g_no_rdclr
      logic unused_rd;
      assign unused_rd = rd_reg_data ^ rd_inj_data;
      assign rdclr_vec = '0;
   end

   assign clr_vec = w1c_vec | rdclr_vec;

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      cvt_irq_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_vec[i]),
         .clr_i (clr_vec[i]),
         .q_o   (flag_q[i])
      );
   end

   cvt_irq_regif #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .NFLAG  (NFLAG)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .flags_i   (flag_q),
      .w1c_o     (w1c_vec),
      .en_o      (en_vec),
      .bus_rdata (bus_rdata)
   );

   cvt_irq_combine #(
      .NFLAG   (NFLAG),
      .IRQ_REG (IRQ_REG)
   ) u_combine (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flag_q),
      .en_i    (en_vec),
      .irq_o   (irq)
   );
endmodule

// File: rtl/cvt_irq_status_chk.sv
module cvt_irq_status_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned NUM_WDOG = 3,
   parameter bit          RDCLR_EN = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                ev_ready,
   input logic                ev_smp_end,
   input logic                ev_conv_end,
   input logic                ev_seq_end,
   input logic                ev_inj_conv_end,
   input logic                ev_inj_seq_end,
   input logic [NUM_WDOG-1:0] ev_wdog,
   input logic                rd_reg_data,
   input logic                rd_inj_data,
   input logic [6+NUM_WDOG:0] flags,
   input logic                irq
);
   localparam int unsigned NF = 7 + NUM_WDOG;

   logic [NF-1:0] ev_all;
   logic [NF-1:0] wr_ones;
   logic          wdata_hi_unused;

   // event inputs gathered by bit position; bit 4 holds no direct event
   assign ev_all  = {ev_wdog, ev_inj_seq_end, ev_inj_conv_end, 1'b0,
                     ev_seq_end, ev_conv_end, ev_smp_end, ev_ready};
   assign wr_ones = (bus_wr && bus_addr == '0) ? bus_wdata[NF-1:0] : '0;
   assign wdata_hi_unused = ^bus_wdata[DATA_W-1:NF];

   // R2, R4: every event lands, whatever clear arrives with it
   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_all != '0) |=> ((flags & $past(ev_all)) == $past(ev_all)));

   // R3: write-one clears flags that see no concurrent event
   a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_ones & ~ev_all & ~(NF'(1) << 4)) != '0) |=>
      ((flags & $past(wr_ones & ~ev_all & ~(NF'(1) << 4))) == '0));

   // R5: data-register read strobes empty the conversion flags
   a_r5_reg_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (RDCLR_EN && rd_reg_data && !ev_conv_end) |=> !flags[2]);
   a_r5_inj_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (RDCLR_EN && rd_inj_data && !ev_inj_conv_end) |=> !flags[5]);

   // R6: overrun follows a conversion end on a pending flag, and only then
   a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_conv_end && flags[2]) |=> flags[4]);
   a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[4]) |-> $past(ev_conv_end && flags[2]));

   // R8: nothing flagged for two cycles means no interrupt
   a_r8_quiet_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags == '0) && ($past(flags) == '0)) |-> !irq);
endmodule

bind cvt_irq_status cvt_irq_status_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .NUM_WDOG (NUM_WDOG),
   .RDCLR_EN (RDCLR_EN)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .bus_wr          (bus_wr),
   .bus_addr        (bus_addr),
   .bus_wdata       (bus_wdata),
   .ev_ready        (ev_ready),
   .ev_smp_end      (ev_smp_end),
   .ev_conv_end     (ev_conv_end),
   .ev_seq_end      (ev_seq_end),
   .ev_inj_conv_end (ev_inj_conv_end),
   .ev_inj_seq_end  (ev_inj_seq_end),
   .ev_wdog         (ev_wdog),
   .rd_reg_data     (rd_reg_data),
   .rd_inj_data     (rd_inj_data),
   .flags           (flag_q),
   .irq             (irq)
);

// File: tb/cvt_irq_status_bench.sv
`timescale 1ns/1ps
module cvt_irq_status_bench;
   localparam int DW = 32;
   localparam int AW = 2;
   localparam int NW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_rd = 0, bus_wr = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          ev_ready = 0, ev_smp_end = 0, ev_conv_end = 0, ev_seq_end = 0;
   logic          ev_inj_conv_end = 0, ev_inj_seq_end = 0;
   logic [NW-1:0] ev_wdog = '0;
   logic          rd_reg_data = 0, rd_inj_data = 0;
   logic          irq;

   int    n_chk = 0, n_bad = 0;
   string cur_req = "R1";
   bit    done = 0;

   // behavioural reference state
   bit [9:0] m_flag, m_en;

   always #10 clk = ~clk;  // 50 MHz

   cvt_irq_status u_cvt_irq_status (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_ready(ev_ready), .ev_smp_end(ev_smp_end), .ev_conv_end(ev_conv_end),
      .ev_seq_end(ev_seq_end), .ev_inj_conv_end(ev_inj_conv_end),
      .ev_inj_seq_end(ev_inj_seq_end), .ev_wdog(ev_wdog),
      .rd_reg_data(rd_reg_data), .rd_inj_data(rd_inj_data), .irq(irq)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   // model update at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_flag <= '0;
         m_en   <= '0;
      end else begin
         bit [9:0] s, c;
         s = '0; c = '0;
         s[0] = ev_ready; s[1] = ev_smp_end; s[2] = ev_conv_end;
         s[3] = ev_seq_end; s[5] = ev_inj_conv_end; s[6] = ev_inj_seq_end;
         for (int k = 0; k < NW; k++) s[7+k] = ev_wdog[k];
         if (ev_conv_end && m_flag[2]) s[4] = 1'b1;
         if (bus_wr && bus_addr == 0) c = bus_wdata[9:0];
         if (rd_reg_data) c[2] = 1'b1;
         if (rd_inj_data) c[5] = 1'b1;
         m_flag <= s | (m_flag & ~c);
         if (bus_wr && bus_addr == 1) m_en <= bus_wdata[9:0];
      end
   end

   // compare every cycle, well after inputs settle
   initial begin
      forever begin
         @(posedge clk);
         #14;
         if (!done) begin
            logic [31:0] exp_rd;
            exp_rd = '0;
            if (bus_rd && bus_addr == 0) exp_rd = {22'd0, m_flag};
            if (bus_rd && bus_addr == 1) exp_rd = {22'd0, m_en};
            check(bus_rdata == exp_rd, cur_req, bus_rdata, exp_rd);
            check(irq == |(m_flag & m_en), "R8 irq", {31'd0, irq},
                  {31'd0, |(m_flag & m_en)});
         end
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle();
      bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
      ev_ready = 0; ev_smp_end = 0; ev_conv_end = 0; ev_seq_end = 0;
      ev_inj_conv_end = 0; ev_inj_seq_end = 0; ev_wdog = '0;
      rd_reg_data = 0; rd_inj_data = 0;
   endtask

   task automatic drive_ev(input int b);
      case (b)
         0: ev_ready = 1;
         1: ev_smp_end = 1;
         2: ev_conv_end = 1;
         3: ev_seq_end = 1;
         5: ev_inj_conv_end = 1;
         6: ev_inj_seq_end = 1;
         default: if (b >= 7) ev_wdog[b-7] = 1;
      endcase
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      tick(); idle(); bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
      tick(); idle();
   endtask

   task automatic rd_expect(input int a, input logic [31:0] exp, input string req);
      tick(); idle(); bus_rd = 1; bus_addr = AW'(a);
      #2 check(bus_rdata == exp, req, bus_rdata, exp);
      tick(); idle();
   endtask

   task automatic pulse(input int b);
      tick(); idle(); drive_ev(b);
      tick(); idle();
   endtask

   initial begin
      int exp_mask;
      idle();
      repeat (3) tick();
      bus_rd = 1; bus_addr = 0;
      #2 check(bus_rdata == 0, "R1 status in reset", bus_rdata, 0);
      check(irq == 0, "R1 irq in reset", {31'd0, irq}, 0);
      tick(); idle(); rst_n = 1;
      rd_expect(0, 32'h0, "R1 status after reset");
      rd_expect(1, 32'h0, "R1 enable after reset");

      // R2: each event at its bit, sticky
      cur_req = "R2";
      exp_mask = 0;
      for (int b = 0; b < 10; b++) begin
         if (b == 4) continue;
         pulse(b);
         exp_mask |= (1 << b);
         rd_expect(0, exp_mask, "R2 event sets bit");
      end
      rd_expect(0, 32'h3EF, "R2 flags sticky");

      // R6: second conversion end on pending flag
      cur_req = "R6";
      pulse(2);
      rd_expect(0, 32'h3FF, "R6 overrun on pending flag");

      // R3: zeros do nothing, ones clear
      cur_req = "R3";
      wr(0, 32'h0);
      rd_expect(0, 32'h3FF, "R3 write zero no effect");
      wr(0, 32'h0AA);
      rd_expect(0, 32'h355, "R3 partial clear");
      wr(0, 32'hFFFF_FFFF);
      rd_expect(0, 32'h0, "R3 clear all");

      // R4: set beats clear
      cur_req = "R4";
      tick(); idle(); ev_seq_end = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h8;
      tick(); idle();
      rd_expect(0, 32'h8, "R4 set wins over write clear");
      wr(0, 32'h8);
      pulse(2);
      tick(); idle(); ev_conv_end = 1; rd_reg_data = 1;
      tick(); idle();
      rd_expect(0, 32'h14, "R4 set wins over read clear, R6 overrun");
      wr(0, 32'h3FF);

      // R5: read clear one cycle late
      cur_req = "R5";
      pulse(2);
      tick(); idle(); rd_reg_data = 1; bus_rd = 1; bus_addr = 0;
      #2 check(bus_rdata == 32'h4, "R5 still set in strobe cycle", bus_rdata, 32'h4);
      tick(); idle(); bus_rd = 1; bus_addr = 0;
      #2 check(bus_rdata == 32'h0, "R5 regular read clears", bus_rdata, 32'h0);
      tick(); idle();
      pulse(5);
      tick(); idle(); rd_inj_data = 1;
      tick(); idle();
      rd_expect(0, 32'h0, "R5 injected read clears");

      // R6: no overrun when flag clear
      cur_req = "R6";
      pulse(2);
      tick(); idle(); rd_reg_data = 1;
      tick(); idle();
      pulse(2);
      rd_expect(0, 32'h4, "R6 no overrun after clear");
      wr(0, 32'h3FF);

      // R7: map and unused bits
      cur_req = "R7";
      wr(1, 32'hFFFF_FFFF);
      rd_expect(1, 32'h3FF, "R7 enable width");
      pulse(9);
      rd_expect(2, 32'h0, "R7 unmapped address 2");
      rd_expect(3, 32'h0, "R7 unmapped address 3");
      tick(); idle(); bus_addr = 0;
      #2 check(bus_rdata == 0, "R7 no read no data", bus_rdata, 0);

      // R8: masking
      cur_req = "R8";
      #2 check(irq == 1, "R8 enabled flag raises irq", {31'd0, irq}, 1);
      wr(1, 32'h001);
      #2 check(irq == 0, "R8 masked flag", {31'd0, irq}, 0);
      pulse(0);
      #2 check(irq == 1, "R8 enabled ready raises irq", {31'd0, irq}, 1);
      wr(0, 32'h3FF);
      #2 check(irq == 0, "R8 cleared flags drop irq", {31'd0, irq}, 0);

      // mixed traffic checked against the model each cycle
      cur_req = "R2 R3 R5 R7 mixed";
      for (int n = 0; n < 3000; n++) begin
         tick(); idle();
         for (int b = 0; b < 10; b++)
            if (b != 4 && $urandom_range(5) == 0) drive_ev(b);
         rd_reg_data = ($urandom_range(4) == 0);
         rd_inj_data = ($urandom_range(4) == 0);
         bus_addr = AW'($urandom_range(3));
         case ($urandom_range(5))
            0: begin bus_wr = 1; bus_wdata = $urandom(); end
            1, 2, 3: bus_rd = 1;
            default: ;
         endcase
      end
      tick(); idle();
      tick();
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule